// File: doc/BRIEF.md
# Operand-Size-Aware Register Write Merge

This block is a sixteen-entry, 64-bit general-purpose register bank. Its single write port does not just overwrite the destination. It merges the incoming result into the destination according to the operand size of the producing operation. A full-width write replaces everything. A 32-bit write stores the low half and clears the high half. Byte and 16-bit writes touch only their low bits and keep whatever the register already held above them.

An optional sign-extend request turns any narrow write into a full-register write. The top bit of the narrow source is then replicated up to bit 63. This is how a datapath widens a narrow integer for use as a 64-bit pointer.

Two combinational read ports return complete 64-bit register values. They have no bypass, so a read of the register being written shows the value from before the write until the next rising edge.

Top module: `gpr_sized_wr`

## Requirements
- R1: An active-high reset, sampled on the rising clock edge, clears all sixteen registers to zero.
- R2: With size code 2'b11 (64-bit), a write replaces all 64 bits of the destination with the write data. The sign-extend request has no effect at this size.
- R3: With size code 2'b00 (32-bit, the default when no wide qualifier is given) and sign-extend clear, bits 31:0 take the write data and bits 63:32 become zero. Write data bits 63:32 are ignored, so an all-ones source leaves 0x00000000FFFFFFFF.
- R4: With size code 2'b01 (8-bit) and sign-extend clear, only bits 7:0 take the write data. Bits 63:8 keep their previous contents.
- R5: With size code 2'b10 (16-bit) and sign-extend clear, only bits 15:0 take the write data. Bits 63:16 keep their previous contents.
- R6: With size code 2'b00 and sign-extend set, write data bit 31 is copied into bits 63:32, bits 31:0 take the write data, and the whole register is written.
- R7: With size code 2'b01 or 2'b10 and sign-extend set, the 8-bit or 16-bit source is sign-extended to 64 bits and the whole register is written.
- R8: While write enable is low, no register changes, whatever the index, data, size and sign-extend inputs carry.
- R9: Read ports are combinational. In the cycle that a write to the same index is presented, they return the old value, and the merged value appears after the rising edge.
- R10: A write changes only the register selected by the write index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Destination register index |
| wr_data | input | 64 | Result value to merge |
| wr_size | input | 2 | Operand size: 00 = 32, 01 = 8, 10 = 16, 11 = 64 bits |
| wr_sext | input | 1 | Sign-extend the narrow source to 64 bits |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 64 | Read port A value |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 64 | Read port B value |

## Verification
The assertions assume that every write input is driven to a known value while write enable is high. They also assume that reset is asserted at the first clock edge, because the reset property has no reset to disable it. The stimulus meets both assumptions: it drives every input from time zero and holds reset across several edges before any write. It then sweeps every index through all four size codes with sign-extend both clear and set, using data whose byte, 16-bit and 32-bit sign bits take both values. Because the registers carry earlier, non-zero contents into each narrow write, the preserved upper bits are always visible.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    // Operand-size code; 2'b00 is the default 32-bit width
    typedef enum logic [1:0] {
        OPSZ_WORD = 2'b00,
        OPSZ_BYTE = 2'b01,
        OPSZ_HALF = 2'b10,
        OPSZ_FULL = 2'b11
    } opsz_e;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

endpackage

// File: rtl/gpr_merge.sv
module gpr_merge
    import gpr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    input  opsz_e             size,
    input  logic              sext,
    output logic [DATA_W-1:0] merged
);
    localparam int WORD_W = DATA_W / 2;

    logic [DATA_W-1:0] byte_sx, half_sx, word_sx, word_zx;
    logic [DATA_W-1:0] byte_keep, half_keep;

    // Candidate results for every narrow width
    assign byte_sx   = {{(DATA_W-BYTE_W){new_val[BYTE_W-1]}}, new_val[BYTE_W-1:0]};
    assign half_sx   = {{(DATA_W-HALF_W){new_val[HALF_W-1]}}, new_val[HALF_W-1:0]};
    assign word_sx   = {{(DATA_W-WORD_W){new_val[WORD_W-1]}}, new_val[WORD_W-1:0]};
    assign word_zx   = {{(DATA_W-WORD_W){1'b0}}, new_val[WORD_W-1:0]};
    assign byte_keep = {old_val[DATA_W-1:BYTE_W], new_val[BYTE_W-1:0]};
    assign half_keep = {old_val[DATA_W-1:HALF_W], new_val[HALF_W-1:0]};

    always_comb begin
        unique case (size)
            OPSZ_FULL: merged = new_val;
            OPSZ_WORD: merged = sext ? word_sx : word_zx;
            OPSZ_BYTE: merged = sext ? byte_sx : byte_keep;
            OPSZ_HALF: merged = sext ? half_sx : half_keep;
            default:   merged = new_val;
        endcase
    end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 widx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        logic [DATA_W-1:0] entry_q;
        logic              hit;

        assign hit = we && (widx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q <= '0;
            end else if (hit) begin
                entry_q <= wdata;
            end
        end

        assign q[g] = entry_q;
    end

endmodule

// File: rtl/gpr_sized_wr.sv
module gpr_sized_wr
    import gpr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_size,
    input  logic              wr_sext,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
    logic [DATA_W-1:0]               dest_old;
    logic [DATA_W-1:0]               merged;
    opsz_e                           size_sel;

    assign size_sel = opsz_e'(wr_size);
    assign dest_old = bank_q[wr_idx];

    gpr_merge #(.DATA_W(DATA_W)) u_merge (
        .old_val (dest_old),
        .new_val (wr_data),
        .size    (size_sel),
        .sext    (wr_sext),
        .merged  (merged)
    );

    gpr_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .widx  (wr_idx),
        .wdata (merged),
        .q     (bank_q)
    );

    // Combinational reads, no bypass of the pending write
    assign rd_a_data = bank_q[rd_a_idx];
    assign rd_b_data = bank_q[rd_b_idx];

endmodule

// File: rtl/gpr_sized_wr_chk.sv
module gpr_sized_wr_chk #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [DATA_W-1:0]               wr_data,
    input logic [1:0]                      wr_size,
    input logic                            wr_sext,
    input logic [NUM_REGS-1:0][DATA_W-1:0] reg_q
);
    localparam int WORD_W = DATA_W / 2;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (reg_q == '0));  // R1

    AST_FULL_REPLACE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b11) |=> (reg_q[$past(wr_idx)] == $past(wr_data)));  // R2

    AST_WORD_ZERO_HI: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b00 && !wr_sext) |=>
        (reg_q[$past(wr_idx)] == {{(DATA_W-WORD_W){1'b0}}, $past(wr_data[WORD_W-1:0])}));  // R3

    AST_BYTE_KEEP_HI: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b01 && !wr_sext) |=>
        (reg_q[$past(wr_idx)][DATA_W-1:8] == $past(reg_q[wr_idx][DATA_W-1:8]) &&
         reg_q[$past(wr_idx)][7:0] == $past(wr_data[7:0])));  // R4

    AST_HALF_KEEP_HI: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b10 && !wr_sext) |=>
        (reg_q[$past(wr_idx)][DATA_W-1:16] == $past(reg_q[wr_idx][DATA_W-1:16]) &&
         reg_q[$past(wr_idx)][15:0] == $past(wr_data[15:0])));  // R5

    AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b00 && wr_sext) |=>
        (reg_q[$past(wr_idx)] ==
         {{(DATA_W-WORD_W){$past(wr_data[WORD_W-1])}}, $past(wr_data[WORD_W-1:0])}));  // R6

    AST_BYTE_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b01 && wr_sext) |=>
        (reg_q[$past(wr_idx)] == {{(DATA_W-8){$past(wr_data[7])}}, $past(wr_data[7:0])}));  // R7

    AST_HALF_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b10 && wr_sext) |=>
        (reg_q[$past(wr_idx)] == {{(DATA_W-16){$past(wr_data[15])}}, $past(wr_data[15:0])}));  // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(reg_q));  // R8

endmodule

bind gpr_sized_wr gpr_sized_wr_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_size (wr_size),
    .wr_sext (wr_sext),
    .reg_q   (bank_q)
);

// File: tb/tb_gpr_sized_wr.sv
`timescale 1ns/1ps
module tb_gpr_sized_wr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_size = '0;
    logic        wr_sext = 1'b0;
    logic [3:0]  rd_a_idx = '0;
    logic [63:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [63:0] rd_b_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [63:0] model [16];

    always #5 clk = ~clk;

    gpr_sized_wr dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_size(wr_size), .wr_sext(wr_sext), .rd_a_idx(rd_a_idx),
        .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected merge, computed from the size rules
    function automatic logic [63:0] expect_val(input logic [63:0] old, input logic [63:0] d,
                                               input logic [1:0] sz, input logic sx);
        case (sz)
            2'b11:   return d;
            2'b00:   return sx ? 64'(signed'(d[31:0])) : {32'h0, d[31:0]};
            2'b01:   return sx ? 64'(signed'(d[7:0]))  : {old[63:8], d[7:0]};
            default: return sx ? 64'(signed'(d[15:0])) : {old[63:16], d[15:0]};
        endcase
    endfunction

    function automatic string tag(input logic [1:0] sz, input logic sx);
        if (sz == 2'b11) return "R2";
        if (sz == 2'b00) return sx ? "R6" : "R3";
        if (sz == 2'b01) return sx ? "R7" : "R4";
        return sx ? "R7" : "R5";
    endfunction

    function automatic logic [63:0] pattern(input int k, input logic [3:0] idx);
        case (k)
            0:       return 64'hFFFF_FFFF_FFFF_FFFF;
            1:       return 64'h5A5A_C3C3_7FFF_7F7F ^ {60'h0, idx};
            2:       return 64'h1234_5678_8000_8080 ^ {56'h0, idx, 4'h0};
            default: return {idx, 12'hE1D, 48'h0F0F_A5A5_C8F1} ^ 64'(idx) * 64'h0101;
        endcase
    endfunction

    task automatic do_write(input logic [3:0] idx, input logic [63:0] d,
                            input logic [1:0] sz, input logic sx);
        logic [63:0] exp;
        logic [3:0]  nb;
        nb = idx + 4'd1;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_size = sz; wr_sext = sx;
        rd_a_idx = idx; rd_b_idx = nb;
        #1;
        check("R9 old value before edge", rd_a_data, model[idx]);
        exp = expect_val(model[idx], d, sz, sx);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check(tag(sz, sx), rd_a_data, exp);
        check("R10 neighbour untouched", rd_b_data, model[nb]);
        model[idx] = exp;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 64'h0;
        repeat (3) @(posedge clk);
        #1;
        // R1: poke registers during reset, then confirm all zero
        rst = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 64'hDEAD_BEEF_0000_1111; wr_size = 2'b11;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i);
            #1;
            check("R1 reset clear", rd_a_data, 64'h0);
        end

        // R2 prefill with distinctive full values
        for (int i = 0; i < 16; i++)
            do_write(4'(i), 64'hA5C3_96F0_1E2D_3C4B ^ (64'(i) << 20), 2'b11, 1'b0);

        // R3: all-ones 32-bit write yields 0x00000000FFFFFFFF
        do_write(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0);
        check("R3 all-ones word", rd_a_data, 64'h0000_0000_FFFF_FFFF);

        // Sweep: index x pattern x size x sign-extend
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 4; s++)
                    for (int x = 0; x < 2; x++) begin
                        if (s == 2) do_write(4'(i), 64'hFFFF_0000_0000_0000 ^ (64'(i) << 8),
                                             2'b11, 1'b0);
                        do_write(4'(i), pattern(k, 4'(i)) ^ (64'(s) << 40), 2'(s), x[0]);
                    end

        // R8: write enable low with busy inputs
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_en = 1'b0; wr_idx = 4'(i); wr_data = ~model[i]; wr_size = 2'(i); wr_sext = i[0];
            @(posedge clk);
            #1;
            rd_a_idx = 4'(i);
            #1;
            check("R8 disabled write ignored", rd_a_data, model[i]);
        end
        for (int i = 0; i < 16; i++) begin
            rd_b_idx = 4'(i);
            #1;
            check("R8 full bank unchanged", rd_b_data, model[i]);
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule